// File: doc/BRIEF.md
# UART FIFO to DMA Handshake Bridge

This block lets an external DMA engine feed a UART's transmit FIFO and drain its receive FIFO, so that the CPU does not have to move each character through registers. A three-bit control register sets three things independently: whether the transmit channel runs, whether the receive channel runs, and whether receive line errors are reported to the DMA engine.

Each channel uses a request/acknowledge pair. The bridge raises a request while its channel is enabled and the FIFO on that side can take or supply a character. Each acknowledge from the DMA engine moves exactly one byte: it becomes a FIFO push on the transmit side and a FIFO pop on the receive side. The DMA engine always sees 8-bit data. The per-character status bits held in the receive FIFO are never placed on the DMA data lines. If error reporting is enabled, a character flagged with break, parity or framing status raises the end-of-transfer line in the same cycle as its acknowledge.

The request and transfer strobes are combinational from the control register and the FIFO flags. A request therefore follows the FIFO's own full and empty flags, and it drops on the first clock edge after its enable bit is cleared.

Top module: `uart_dma_bridge`

## Requirements
- R1: After reset the control register reads 000, and tx_req, rx_req, txf_push, rxf_pop and rx_end are all low, whatever the acknowledge inputs do.
- R2: A cycle with cfg_wr high loads cfg_wdata into the control register at the clock edge, and cfg_q shows the new value from then on. The bits are: bit 0 enables transmit, bit 1 enables receive, bit 2 enables error reporting.
- R3: tx_req is high exactly when control bit 0 is set and txf_full is low. txf_push is high exactly when tx_req and tx_ack are both high, and txf_wdata then equals tx_data.
- R4: When tx_req is low (transmit disabled or FIFO full), tx_ack causes no push.
- R5: rx_req is high exactly when control bit 1 is set and rxf_empty is low. rxf_pop is high exactly when rx_req and rx_ack are both high, so each acknowledge pops one character.
- R6: When rx_req is low (receive disabled or FIFO empty), rx_ack causes no pop.
- R7: rx_end is high only in a pop cycle, and only when control bit 2 is set and at least one of the character's status bits is set (rxf_stat bit 0 break, bit 1 parity error, bit 2 framing error). Otherwise it stays low.
- R8: rx_data always equals the 8 character bits of rxf_rdata, whatever value rxf_stat holds.
- R9: A control write that clears an enable bit drops that channel's request from the clock edge that performs the write, and no push or pop follows on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control write value (bit0 tx, bit1 rx, bit2 error report) |
| cfg_q | output | 3 | Current control register value |
| tx_req | output | 1 | Transmit request to the DMA engine |
| tx_ack | input | 1 | Transmit acknowledge from the DMA engine |
| tx_data | input | 8 | Character supplied by the DMA engine |
| txf_full | input | 1 | Transmit FIFO full flag |
| txf_push | output | 1 | Transmit FIFO push strobe |
| txf_wdata | output | 8 | Character written into the transmit FIFO |
| rx_req | output | 1 | Receive request to the DMA engine |
| rx_ack | input | 1 | Receive acknowledge from the DMA engine |
| rx_data | output | 8 | Character delivered to the DMA engine |
| rx_end | output | 1 | End-of-transfer pulse for an errored character |
| rxf_empty | input | 1 | Receive FIFO empty flag |
| rxf_pop | output | 1 | Receive FIFO pop strobe |
| rxf_rdata | input | 8 | Character at the head of the receive FIFO |
| rxf_stat | input | 3 | Head character status: bit0 break, bit1 parity, bit2 framing |

## Verification
The handshake is tried with every combination of the channel enables and the FIFO flags, with acknowledges both present and absent. This separates a request that is correctly held off by a full or empty FIFO from one held off by a cleared enable. The receive path gets each status bit on its own, all status bits together, and clean characters, first with error reporting on and then with it off. This shows that end-of-transfer depends on the report bit and on whether a pop actually happens, and that status never leaks into the data byte. Directed cases then clear an enable while an acknowledge is pending, and apply reset with both channels active.

// File: rtl/uart_dma_bridge.sv
module uart_dma_bridge #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_wdata,
  output logic [2:0]        cfg_q,
  output logic              tx_req,
  input  logic              tx_ack,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              txf_full,
  output logic              txf_push,
  output logic [DATA_W-1:0] txf_wdata,
  output logic              rx_req,
  input  logic              rx_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_end,
  input  logic              rxf_empty,
  output logic              rxf_pop,
  input  logic [DATA_W-1:0] rxf_rdata,
  input  logic [STAT_W-1:0] rxf_stat
);
  localparam int TX_EN  = 0;
  localparam int RX_EN  = 1;
  localparam int ERR_EN = 2;

  logic [2:0] ctl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl <= '0;
    else if (cfg_wr) ctl <= cfg_wdata;

  assign cfg_q     = ctl;

  assign tx_req    = ctl[TX_EN] & ~txf_full;
  assign txf_push  = tx_req & tx_ack;
  assign txf_wdata = tx_data;

  assign rx_req    = ctl[RX_EN] & ~rxf_empty;
  assign rxf_pop   = rx_req & rx_ack;
  assign rx_data   = rxf_rdata;
  assign rx_end    = rxf_pop & ctl[ERR_EN] & (|rxf_stat);
endmodule

module uart_dma_bridge_chk #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [2:0]        cfg_wdata,
  input logic [2:0]        cfg_q,
  input logic              tx_req,
  input logic              tx_ack,
  input logic [DATA_W-1:0] tx_data,
  input logic              txf_push,
  input logic [DATA_W-1:0] txf_wdata,
  input logic              rx_req,
  input logic              rx_ack,
  input logic              rx_end,
  input logic              rxf_pop
);
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_q == $past(cfg_wdata));

  p_push_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txf_push |-> tx_ack && txf_wdata == tx_data);

  p_no_push_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[0] |-> !txf_push);

  p_pop_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_pop |-> rx_ack);

  p_no_pop_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[1] |-> !rxf_pop);

  p_end_with_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> rxf_pop && cfg_q[2]);

  p_tx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_wdata[0] |=> !tx_req);

  p_rx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_wdata[1] |=> !rx_req);
endmodule

bind uart_dma_bridge uart_dma_bridge_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
  .tx_req(tx_req), .tx_ack(tx_ack), .tx_data(tx_data), .txf_push(txf_push),
  .txf_wdata(txf_wdata), .rx_req(rx_req), .rx_ack(rx_ack), .rx_end(rx_end),
  .rxf_pop(rxf_pop)
);

// File: tb/uart_dma_bridge_test.sv
module uart_dma_bridge_test;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [2:0] cfg_wdata = 0, cfg_q;
  logic tx_req, tx_ack = 0, txf_full = 0, txf_push;
  logic [7:0] tx_data = 0, txf_wdata;
  logic rx_req, rx_ack = 0, rx_end, rxf_empty = 1, rxf_pop;
  logic [7:0] rx_data, rxf_rdata = 0;
  logic [2:0] rxf_stat = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_dma_bridge uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .tx_req(tx_req), .tx_ack(tx_ack), .tx_data(tx_data), .txf_full(txf_full),
    .txf_push(txf_push), .txf_wdata(txf_wdata), .rx_req(rx_req), .rx_ack(rx_ack),
    .rx_data(rx_data), .rx_end(rx_end), .rxf_empty(rxf_empty), .rxf_pop(rxf_pop),
    .rxf_rdata(rxf_rdata), .rxf_stat(rxf_stat)
  );

  typedef struct packed {
    logic [2:0] ctl;
    logic       full, tack;
    logic [7:0] tdat;
    logic       empty, rack;
    logic [7:0] rdat;
    logic [2:0] stat;
    logic       e_treq, e_push, e_rreq, e_pop, e_end;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{3'b001, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, 8'h00, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{3'b001, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'b000, 1'b0, 1'b1, 8'h11, 1'b0, 1'b1, 8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'b010, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h5A, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{3'b010, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'b110, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h81, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'b110, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h82, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'b110, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h83, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'b010, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h84, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{3'b110, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h85, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{3'b111, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b1, 8'hFF, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{3'b100, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    txf_full = 0; rxf_empty = 0; tx_ack = 1; rx_ack = 1; rxf_stat = 3'd7;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    // R1 reset state
    chk("R1 cfg_q", {5'd0, cfg_q}, 8'd0);
    chk("R1 strobes", {3'd0, tx_req, rx_req, txf_push, rxf_pop, rx_end}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      write_cfg(TBL[i].ctl);
      txf_full = TBL[i].full; tx_ack = TBL[i].tack; tx_data = TBL[i].tdat;
      rxf_empty = TBL[i].empty; rx_ack = TBL[i].rack; rxf_rdata = TBL[i].rdat;
      rxf_stat = TBL[i].stat;
      #5;
      chk("R2 cfg_q", {5'd0, cfg_q}, {5'd0, TBL[i].ctl});
      chk("R3/R4 tx_req", {7'd0, tx_req}, {7'd0, TBL[i].e_treq});
      chk("R3/R4 txf_push", {7'd0, txf_push}, {7'd0, TBL[i].e_push});
      if (TBL[i].e_push) chk("R3 txf_wdata", txf_wdata, TBL[i].tdat);
      chk("R5/R6 rx_req", {7'd0, rx_req}, {7'd0, TBL[i].e_rreq});
      chk("R5/R6 rxf_pop", {7'd0, rxf_pop}, {7'd0, TBL[i].e_pop});
      chk("R7 rx_end", {7'd0, rx_end}, {7'd0, TBL[i].e_end});
      chk("R8 rx_data", rx_data, TBL[i].rdat);
    end

    // R9: clear tx enable while an acknowledge is held
    write_cfg(3'b011);
    txf_full = 0; rxf_empty = 0; tx_ack = 1; rx_ack = 1; rxf_stat = 3'd0;
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = 3'b010;
    #5;
    chk("R9 tx_req before edge", {7'd0, tx_req}, 8'd1);
    @(negedge clk);
    cfg_wr = 0; #5;
    chk("R9 tx_req after clear", {7'd0, tx_req}, 8'd0);
    chk("R9 no push after clear", {7'd0, txf_push}, 8'd0);
    chk("R9 rx still running", {7'd0, rxf_pop}, 8'd1);
    // R9: clear rx enable
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = 3'b000;
    @(negedge clk);
    cfg_wr = 0; #5;
    chk("R9 rx_req after clear", {7'd0, rx_req}, 8'd0);
    chk("R9 no pop after clear", {7'd0, rxf_pop}, 8'd0);

    // R1: reset while both channels active
    write_cfg(3'b111);
    rxf_stat = 3'd2; #5;
    chk("R7 end before reset", {7'd0, rx_end}, 8'd1);
    rst_n = 0; #2;
    chk("R1 cfg_q in reset", {5'd0, cfg_q}, 8'd0);
    chk("R1 strobes in reset", {3'd0, tx_req, rx_req, txf_push, rxf_pop, rx_end}, 8'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    finish_run();
  end
endmodule